// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Mapper

This block is the internal data store of a small 8-bit microcontroller. It holds 128 bytes of RAM, a stack pointer, and a bus that leads out to the special function registers (SFRs). Three kinds of access reach the same RAM bytes. The first is a working-register access: a 3-bit register number, moved into one of four banks by a 2-bit bank select. The second is a direct byte access with an 8-bit address. The third is a single-bit read or write with an 8-bit bit address.

Direct addresses with the top bit set, and bit addresses with the top bit set, never touch RAM. They are passed to the SFR bus instead. A bit write to an SFR is carried out as a read-modify-write within the same cycle. The external SFR logic reports through `sfr_ack` whether the addressed SFR exists.

All reads are combinational. RAM and stack pointer updates take effect on the next rising clock edge. Push pre-increments the stack pointer before it writes. Pop reads first and then decrements.

Top module: `dmem_mapper`

## Requirements
- R1: While `rst_n` is low, `sp` is 07h and every RAM byte is 00h.
- R2: With bank `bank_sel` = b, register number n maps to RAM byte b*8+n. Register reads and writes reach the same byte as a direct access to that address. For example, bank 3 R4 is RAM 1Ch.
- R3: A direct access with `dir_addr` 00h–7Fh reads RAM combinationally on `dir_rdata`. A direct write takes effect at the next rising edge.
- R4: A direct access with `dir_addr` 80h–FFh drives `sfr_addr` = `dir_addr` and never reads or writes RAM. The bus carries the data on `sfr_wdata` and the write strobe on `sfr_we`.
- R5: Bit address k below 80h selects RAM byte 20h + k[6:3], bit position k[2:0]. `bit_rdata` returns that bit. A bit write replaces only that bit with `bit_wval`.
- R6: Bit address k at 80h or above selects SFR byte k with bits [2:0] cleared, bit position k[2:0]. A bit write drives `sfr_wdata` equal to `sfr_rdata` with only that bit replaced.
- R7: When an SFR access meets `sfr_ack` low, the read data is 00h, `sfr_we` stays low, and `acc_err` is high in the same cycle.
- R8: A push sets `sp` to sp+1 and writes `push_data` to RAM[sp+1]. A pop returns RAM[sp] on `pop_data` in the same cycle and sets `sp` to sp-1.
- R9: `stk_err` is high, and neither `sp` nor RAM changes, in three cases: push with `sp` ≥ 7Fh, pop with `sp` ≥ 80h, or push and pop in the same cycle.
- R10: When several writes target one RAM byte in the same cycle, the order of precedence is direct write, then register write, then push, then bit write.
- R11: When a direct SFR access and a bit SFR access occur in the same cycle, the direct access owns the bus. The bit access is dropped, and `acc_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Working-register bank select |
| reg_num | input | 3 | Working-register number |
| reg_we | input | 1 | Working-register write strobe |
| reg_wdata | input | 8 | Working-register write data |
| reg_rdata | output | 8 | Working-register read data |
| dir_en | input | 1 | Direct access valid |
| dir_we | input | 1 | Direct access is a write |
| dir_addr | input | 8 | Direct byte address |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| bit_en | input | 1 | Bit access valid |
| bit_we | input | 1 | Bit access is a write |
| bit_addr | input | 8 | Bit address |
| bit_wval | input | 1 | Value written to the bit |
| bit_rdata | output | 1 | Current value of the addressed bit |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| push_data | input | 8 | Byte to push |
| pop_data | output | 8 | Byte at top of stack |
| sp | output | 8 | Stack pointer |
| stk_err | output | 1 | Stack access rejected |
| acc_err | output | 1 | SFR access unassigned or dropped |
| sfr_addr | output | 8 | SFR bus address |
| sfr_re | output | 1 | SFR bus read strobe |
| sfr_we | output | 1 | SFR bus write strobe |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_rdata | input | 8 | SFR bus read data |
| sfr_ack | input | 1 | Addressed SFR exists |

## Verification
The following are due in the same cycle as the request: read data, bit values, pop data, the error flags, and everything on the SFR bus. The bench drives each request at a falling edge and samples these results 1 ns later. RAM contents and the stack pointer change only at the next rising edge. The bench checks them at the following falling edge, either through a later direct or register read or on `sp`, so every sample sits one full register stage after its stimulus.

// File: rtl/dmem_mapper.sv
module dmem_mapper #(
  parameter int DW = 8,
  parameter logic [7:0] SP_INIT = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_sel,
  input  logic [2:0]    reg_num,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dir_en,
  input  logic          dir_we,
  input  logic [7:0]    dir_addr,
  input  logic [DW-1:0] dir_wdata,
  output logic [DW-1:0] dir_rdata,
  input  logic          bit_en,
  input  logic          bit_we,
  input  logic [7:0]    bit_addr,
  input  logic          bit_wval,
  output logic          bit_rdata,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] pop_data,
  output logic [7:0]    sp,
  output logic          stk_err,
  output logic          acc_err,
  output logic [7:0]    sfr_addr,
  output logic          sfr_re,
  output logic          sfr_we,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  input  logic          sfr_ack
);
  localparam int RAM_BYTES = 128;
  localparam logic [7:0] SP_TOP = 8'h7F;

  logic [DW-1:0] ram [RAM_BYTES];
  logic [7:0]    sp_q;

  wire [6:0] reg_loc = {2'b00, bank_sel, reg_num};
  assign reg_rdata = ram[reg_loc];

  wire dir_sfr = dir_en & dir_addr[7];
  wire dir_ram = dir_en & ~dir_addr[7];
  wire [DW-1:0] sfr_val = sfr_ack ? sfr_rdata : '0;
  assign dir_rdata = dir_sfr ? sfr_val : dir_ram ? ram[dir_addr[6:0]] : '0;

  wire bit_sfr_req = bit_en & bit_addr[7];
  wire bit_drop    = bit_sfr_req & dir_sfr;
  wire bit_sfr     = bit_sfr_req & ~dir_sfr;
  wire bit_ram     = bit_en & ~bit_addr[7];
  wire [6:0] bit_loc = {3'b010, bit_addr[6:3]};
  wire [2:0] bit_pos = bit_addr[2:0];

  logic [DW-1:0] bit_src, bit_new;
  always_comb begin
    bit_src = bit_sfr ? sfr_val : bit_ram ? ram[bit_loc] : '0;
    bit_new = bit_src;
    bit_new[bit_pos] = bit_wval;
  end
  assign bit_rdata = bit_src[bit_pos];

  assign sfr_addr  = dir_sfr ? dir_addr : bit_sfr ? {bit_addr[7:3], 3'b000} : 8'h00;
  assign sfr_re    = (dir_sfr & ~dir_we) | bit_sfr;
  assign sfr_we    = sfr_ack & ((dir_sfr & dir_we) | (bit_sfr & bit_we));
  assign sfr_wdata = dir_sfr ? dir_wdata : bit_sfr ? bit_new : '0;
  assign acc_err   = ((dir_sfr | bit_sfr) & ~sfr_ack) | bit_drop;

  wire both_stk = push & pop;
  wire push_ok  = push & ~pop & (sp_q < SP_TOP);
  wire pop_ok   = pop & ~push & ~sp_q[7];
  wire [7:0] sp_inc = sp_q + 8'd1;
  assign stk_err  = both_stk | (push & ~pop & ~push_ok) | (pop & ~push & ~pop_ok);
  assign pop_data = sp_q[7] ? '0 : ram[sp_q[6:0]];
  assign sp       = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_INIT;
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
    end else begin
      if (push_ok) sp_q <= sp_inc;
      else if (pop_ok) sp_q <= sp_q - 8'd1;
      if (bit_ram && bit_we) ram[bit_loc] <= bit_new;
      if (push_ok) ram[sp_inc[6:0]] <= push_data;
      if (reg_we) ram[reg_loc] <= reg_wdata;
      if (dir_ram && dir_we) ram[dir_addr[6:0]] <= dir_wdata;
    end
  end
endmodule

// File: rtl/dmem_mapper_chk.sv
module dmem_mapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_en,
  input logic [7:0] dir_addr,
  input logic       bit_en,
  input logic       bit_we,
  input logic [7:0] bit_addr,
  input logic       push,
  input logic       pop,
  input logic [7:0] sp,
  input logic       stk_err,
  input logic       acc_err,
  input logic [7:0] sfr_addr,
  input logic       sfr_we,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic       sfr_ack
);
  // R1
  sp_reset_chk: assert property (@(posedge clk) !rst_n |=> sp == 8'h07);
  // R4
  dir_sfr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en && dir_addr[7] |-> sfr_addr == dir_addr);
  // R7
  unassigned_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_ack |-> !sfr_we);
  // R8
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !stk_err |=> sp == $past(sp) + 8'd1);
  // R9
  stack_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> sp == $past(sp));
  // R6
  sfr_bit_preserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && bit_we && bit_addr[7] && !(dir_en && dir_addr[7]) && sfr_we
    |-> $countones(sfr_wdata ^ sfr_rdata) <= 1);
  // R11
  contention_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en && dir_addr[7] && bit_en && bit_addr[7] |-> acc_err);
endmodule

bind dmem_mapper dmem_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_en(dir_en), .dir_addr(dir_addr),
  .bit_en(bit_en), .bit_we(bit_we), .bit_addr(bit_addr),
  .push(push), .pop(pop), .sp(sp), .stk_err(stk_err), .acc_err(acc_err),
  .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
  .sfr_rdata(sfr_rdata), .sfr_ack(sfr_ack)
);

// File: tb/dmem_mapper_test.sv
module dmem_mapper_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [1:0] bank_sel = 0;
  logic [2:0] reg_num = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic dir_en = 0, dir_we = 0;
  logic [7:0] dir_addr = 0, dir_wdata = 0, dir_rdata;
  logic bit_en = 0, bit_we = 0, bit_wval = 0, bit_rdata;
  logic [7:0] bit_addr = 0;
  logic push = 0, pop = 0;
  logic [7:0] push_data = 0, pop_data, sp;
  logic stk_err, acc_err;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic sfr_re, sfr_we, sfr_ack;
  logic [7:0] sfr_p0 = 0, sfr_p1 = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sfr_ack   = (sfr_addr == 8'h80) || (sfr_addr == 8'h90);
  assign sfr_rdata = sfr_addr == 8'h80 ? sfr_p0 : sfr_addr == 8'h90 ? sfr_p1 : 8'hEE;
  always @(posedge clk) if (sfr_we) begin
    if (sfr_addr == 8'h80) sfr_p0 <= sfr_wdata;
    if (sfr_addr == 8'h90) sfr_p1 <= sfr_wdata;
  end

  dmem_mapper uut (.*);

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_we = 0; dir_en = 0; dir_we = 0; bit_en = 0; bit_we = 0; push = 0; pop = 0;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic dwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); idle(); dir_en = 1; dir_we = 1; dir_addr = a; dir_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic dread(input logic [7:0] a, input logic [7:0] exp, input string req);
    idle(); dir_en = 1; dir_addr = a; #1;
    chk(dir_rdata == exp, req, dir_rdata, exp);
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(sp == 8'h07, "R1 sp", sp, 8'h07);
    dread(8'h10, 8'h00, "R1 ram");
    reg_num = 3'd7; #1;
    chk(reg_rdata == 8'h00, "R1 reg", reg_rdata, 8'h00);
  endtask

  task automatic t_regbank();
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); idle(); bank_sel = b[1:0]; reg_num = 3'd4; reg_we = 1; reg_wdata = 8'hA0 + b[7:0];
    end
    step();
    dread(8'h1C, 8'hA3, "R2 bank3 R4");
    dread(8'h04, 8'hA0, "R2 bank0 R4");
    dwrite(8'h05, 8'h5A);
    bank_sel = 0; reg_num = 3'd5; #1;
    chk(reg_rdata == 8'h5A, "R2 reg alias", reg_rdata, 8'h5A);
  endtask

  task automatic t_direct();
    dwrite(8'h7F, 8'hC3);
    dread(8'h7F, 8'hC3, "R3 top byte");
    dwrite(8'h10, 8'h11);
    dread(8'h10, 8'h11, "R3 byte 10");
  endtask

  task automatic t_sfr_direct();
    @(negedge clk); idle(); dir_en = 1; dir_we = 1; dir_addr = 8'h90; dir_wdata = 8'hA5; #1;
    chk(sfr_addr == 8'h90 && sfr_we, "R4 bus addr", sfr_addr, 8'h90);
    step();
    chk(sfr_p1 == 8'hA5, "R4 sfr written", sfr_p1, 8'hA5);
    dread(8'h90, 8'hA5, "R4 sfr read");
    dread(8'h10, 8'h11, "R4 ram untouched");
  endtask

  task automatic t_unassigned();
    idle(); dir_en = 1; dir_addr = 8'hA0; #1;
    chk(dir_rdata == 8'h00, "R7 read zero", dir_rdata, 8'h00);
    chk(acc_err == 1'b1, "R7 err", {7'b0, acc_err}, 8'h01);
    dir_we = 1; dir_wdata = 8'h33; #1;
    chk(!sfr_we && acc_err, "R7 write ignored", {7'b0, sfr_we}, 8'h00);
    idle();
  endtask

  task automatic t_bit_ram();
    dwrite(8'h20, 8'hFF);
    @(negedge clk); idle(); bit_en = 1; bit_we = 1; bit_addr = 8'h03; bit_wval = 0;
    @(negedge clk); idle(); bit_en = 1; bit_we = 1; bit_addr = 8'h24; bit_wval = 1;
    step();
    dread(8'h20, 8'hF7, "R5 clear bit 3");
    dread(8'h24, 8'h10, "R5 set bit 24h");
    bit_en = 1; bit_addr = 8'h24; #1;
    chk(bit_rdata == 1'b1, "R5 bit read", {7'b0, bit_rdata}, 8'h01);
    bit_addr = 8'h25; #1;
    chk(bit_rdata == 1'b0, "R5 neighbour bit", {7'b0, bit_rdata}, 8'h00);
    idle();
  endtask

  task automatic t_bit_sfr();
    @(negedge clk); idle(); sfr_p0 = 8'hC1;
    bit_en = 1; bit_we = 1; bit_addr = 8'h83; bit_wval = 1; #1;
    chk(sfr_addr == 8'h80, "R6 byte addr", sfr_addr, 8'h80);
    chk(sfr_wdata == 8'hC9, "R6 rmw data", sfr_wdata, 8'hC9);
    step();
    chk(sfr_p0 == 8'hC9, "R6 sfr after", sfr_p0, 8'hC9);
    bit_en = 1; bit_addr = 8'h87; #1;
    chk(bit_rdata == 1'b1, "R6 bit read", {7'b0, bit_rdata}, 8'h01);
    idle();
  endtask

  task automatic t_contention();
    @(negedge clk); idle(); dir_en = 1; dir_addr = 8'h90;
    bit_en = 1; bit_we = 1; bit_addr = 8'h80; bit_wval = 0; #1;
    chk(acc_err == 1'b1, "R11 err", {7'b0, acc_err}, 8'h01);
    step();
    chk(sfr_p0 == 8'hC9, "R11 bit dropped", sfr_p0, 8'hC9);
  endtask

  task automatic t_priority();
    @(negedge clk); idle(); dir_en = 1; dir_we = 1; dir_addr = 8'h21; dir_wdata = 8'hAA;
    bit_en = 1; bit_we = 1; bit_addr = 8'h08; bit_wval = 1;
    step();
    dread(8'h21, 8'hAA, "R10 byte over bit");
    @(negedge clk); idle(); bank_sel = 0; reg_num = 3'd2; reg_we = 1; reg_wdata = 8'h22;
    dir_en = 1; dir_we = 1; dir_addr = 8'h02; dir_wdata = 8'h99;
    step();
    dread(8'h02, 8'h99, "R10 direct over reg");
  endtask

  task automatic t_stack();
    @(negedge clk); idle(); push = 1; push_data = 8'h3C;
    step();
    chk(sp == 8'h08, "R8 sp after push", sp, 8'h08);
    dread(8'h08, 8'h3C, "R8 pushed byte");
    pop = 1; #1;
    chk(pop_data == 8'h3C, "R8 pop data", pop_data, 8'h3C);
    step();
    chk(sp == 8'h07, "R8 sp after pop", sp, 8'h07);
  endtask

  task automatic t_stack_err();
    @(negedge clk); idle(); push = 1; pop = 1; #1;
    chk(stk_err == 1'b1, "R9 both", {7'b0, stk_err}, 8'h01);
    step();
    chk(sp == 8'h07, "R9 sp held", sp, 8'h07);
    while (sp != 8'h7F) begin push = 1; push_data = sp; step(); end
    dread(8'h7F, 8'h7E, "R8 last push");
    push = 1; push_data = 8'h55; #1;
    chk(stk_err == 1'b1, "R9 overflow", {7'b0, stk_err}, 8'h01);
    step();
    chk(sp == 8'h7F, "R9 sp at top", sp, 8'h7F);
    dread(8'h00, 8'h00, "R9 no wrap write");
    while (sp != 8'hFF) begin pop = 1; step(); end
    pop = 1; #1;
    chk(stk_err == 1'b1, "R9 pop out of range", {7'b0, stk_err}, 8'h01);
    step();
    chk(sp == 8'hFF, "R9 sp held low", sp, 8'hFF);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_regbank();
    t_direct();
    t_sfr_direct();
    t_unassigned();
    t_bit_ram();
    t_bit_sfr();
    t_contention();
    t_priority();
    t_stack();
    t_stack_err();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule